// File: doc/BRIEF.md
# Region access permission checker

This block decides, for each bus transaction presented to it, whether the transaction may reach memory. A request carries a byte address, a read/write direction, the requesting master's ID and a secure/non-secure attribute. The block holds the settings for up to eight protection regions and one global security setting. It returns a registered allow/block verdict one clock after the request, together with a flag saying whether any region matched and the index of the region that decided the outcome.

Each region is a power-of-two window of memory. Its size is a code in which 0 means 4 KB and each step doubles the size. Its base keeps only address bits 31:12, and any base bits below the region size are ignored. Inside a region, reads and writes can each be made ID-checked. Two masked ID comparators decide which masters match, and an invert bit turns the matched set into a denied set. Four security bits gate secure and non-secure reads and writes. A global setting, which after reset admits secure traffic only, separately admits non-secure reads and non-secure writes.

Error capture, interrupts and the bus handshake are handled elsewhere. A simple write port loads the settings.

Top module: `region_guard`

## Requirements
- R1: After reset, rsp_valid is 0, every region is disabled, and the global setting admits secure transactions only. A non-secure request that hits no region is blocked, and a secure one is allowed.
- R2: Each request with req_valid high produces rsp_valid high with its verdict on the following clock. A cycle without a request produces rsp_valid low on the following clock.
- R3: An enabled region hits when the address bits at and above position 12+size equal the same bits of the base. The size code runs 0 (4 KB) to 20 (4 GB), and larger codes act as 20. Base bits below the region size are ignored, so a misaligned base selects the aligned block that contains it. A disabled region never hits.
- R4: In a hit region, the ID check applies to reads only when read protection is set, and to writes only when write protection is set. With the relevant protection clear, any ID passes.
- R5: The ID check passes when comparator A or comparator B matches. A comparator matches when the request ID and the stored ID agree on every bit where the stored mask is 1.
- R6: With the region's invert bit set, the combined A/B match result is inverted before the protection decision.
- R7: A non-secure read is blocked unless the global non-secure-read enable (bit 0) is set. A non-secure write is blocked unless the global non-secure-write enable (bit 1) is set. This applies whether or not a region hits.
- R8: The region security bits are: bit 0 secure read, bit 1 secure write, bit 2 non-secure read, bit 3 non-secure write. After reset they hold 4'b0011. A hit non-secure access needs its non-secure bit. A hit secure access passes if either the secure or the non-secure bit for its direction is set.
- R9: When several enabled regions hit, the request is blocked if any of them blocks it, and rsp_region reports the lowest-numbered blocking region. If none of them blocks, rsp_region reports the lowest-numbered hit region.
- R10: A request that hits no region gives rsp_hit 0 and rsp_region 0, and is allowed unless the global setting (R7) blocks it.
- R11: A write with cfg_we high loads settings on that clock, addressed by cfg_addr = {region[2:0], field[2:0]}. The fields are: 0 control (bit0 enable, bit1 read protect, bit2 write protect, bit3 invert, bits 8:4 size); 1 base (data 31:12); 2 ID A; 3 mask A; 4 ID B; 5 mask B (IDs and masks in data 11:0); 6 security (R8); 7 global (R7), for any region index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 6 | {region index, field} of the write |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 12 | Requesting master ID |
| req_secure | input | 1 | 1 = secure transaction |
| rsp_valid | output | 1 | Verdict present (one clock after request) |
| rsp_allow | output | 1 | 1 = pass, 0 = block |
| rsp_hit | output | 1 | At least one enabled region matched |
| rsp_region | output | 3 | Deciding region index |

## Verification
A wrong stored setting shows up on the very next request aimed at that region, one clock later, as a flipped rsp_allow or a wrong rsp_region. A stale size or base moves the window edge, which shows only for addresses next to the boundary. For that reason the vectors sit on the first and last words of each window and on the first word past it. Overlapping regions are probed in both orders of blame, so that a faulty priority pick reports the wrong index even when the allow bit happens to come out right.

// File: rtl/rgd_pkg.sv
package rgd_pkg;

  typedef enum logic [2:0] {
    FLD_CTL  = 3'd0,
    FLD_BASE = 3'd1,
    FLD_IDA  = 3'd2,
    FLD_MSKA = 3'd3,
    FLD_IDB  = 3'd4,
    FLD_MSKB = 3'd5,
    FLD_SEC  = 3'd6,
    FLD_GLB  = 3'd7
  } fld_e;

  typedef struct packed {
    logic [4:0] size;
    logic       inv;
    logic       wprot;
    logic       rprot;
    logic       en;
  } rctl_t;

  typedef struct packed {
    logic ns_wr;
    logic ns_rd;
    logic s_wr;
    logic s_rd;
  } rsec_t;

  typedef struct packed {
    logic ns_wr;
    logic ns_rd;
  } glb_t;

  localparam int CTL_W = $bits(rctl_t);
  localparam int SEC_W = $bits(rsec_t);
  localparam int GLB_W = $bits(glb_t);

endpackage

// File: rtl/rgd_region.sv
module rgd_region
  import rgd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDW   = 12,
  parameter int DW    = 32,
  parameter int MINSH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  fld_e           wr_fld,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic [IDW-1:0] req_id,
  input  logic           req_secure,
  output logic           hit,
  output logic           blk
);

  localparam int BW   = AW - MINSH;
  localparam int MAXC = BW;
  localparam int SHW  = $clog2(AW + 1);

  rctl_t          ctl_q, ctl_d;
  rsec_t          sec_q, sec_d;
  logic [BW-1:0]  base_q, base_d;
  logic [IDW-1:0] ida_q, ida_d, mska_q, mska_d;
  logic [IDW-1:0] idb_q, idb_d, mskb_q, mskb_d;

  always_comb begin
    ctl_d  = ctl_q;
    sec_d  = sec_q;
    base_d = base_q;
    ida_d  = ida_q;
    mska_d = mska_q;
    idb_d  = idb_q;
    mskb_d = mskb_q;
    case (wr_fld)
      FLD_CTL:  ctl_d  = rctl_t'(wr_data[CTL_W-1:0]);
      FLD_BASE: base_d = wr_data[AW-1:MINSH];
      FLD_IDA:  ida_d  = wr_data[IDW-1:0];
      FLD_MSKA: mska_d = wr_data[IDW-1:0];
      FLD_IDB:  idb_d  = wr_data[IDW-1:0];
      FLD_MSKB: mskb_d = wr_data[IDW-1:0];
      FLD_SEC:  sec_d  = rsec_t'(wr_data[SEC_W-1:0]);
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      sec_q  <= rsec_t'(4'b0011);
      base_q <= '0;
      ida_q  <= '0;
      mska_q <= '0;
      idb_q  <= '0;
      mskb_q <= '0;
    end else if (wr_en) begin
      ctl_q  <= ctl_d;
      sec_q  <= sec_d;
      base_q <= base_d;
      ida_q  <= ida_d;
      mska_q <= mska_d;
      idb_q  <= idb_d;
      mskb_q <= mskb_d;
    end
  end

  // address window: compare only the bits above the region size
  logic [SHW-1:0] shamt;
  logic [AW-1:0]  keep;
  always_comb begin
    if (int'(ctl_q.size) > MAXC) shamt = SHW'(AW);
    else                         shamt = SHW'(MINSH + int'(ctl_q.size));
  end
  assign keep = {AW{1'b1}} << shamt;
  assign hit  = ctl_q.en &&
                ((req_addr & keep) == ({base_q, {MINSH{1'b0}}} & keep));

  // ID comparators and protection
  logic id_match, id_ok, prot_on, sec_ok;
  assign id_match = (((req_id ^ ida_q) & mska_q) == '0) ||
                    (((req_id ^ idb_q) & mskb_q) == '0);
  assign id_ok    = ctl_q.inv ? !id_match : id_match;
  assign prot_on  = req_write ? ctl_q.wprot : ctl_q.rprot;

  always_comb begin
    if (req_secure)
      sec_ok = req_write ? (sec_q.s_wr | sec_q.ns_wr) : (sec_q.s_rd | sec_q.ns_rd);
    else
      sec_ok = req_write ? sec_q.ns_wr : sec_q.ns_rd;
  end

  assign blk = hit && ((prot_on && !id_ok) || !sec_ok);

  // R11: a base write lands in the region on the clock of the strobe
  assert_base_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fld == FLD_BASE) |=> (base_q == $past(wr_data[AW-1:MINSH])));

  // R8: a non-secure read of a hit region lacking the non-secure read bit blocks
  assert_ns_read_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_secure && !req_write && !sec_q.ns_rd) |-> blk);

endmodule

// File: rtl/rgd_pick.sv
module rgd_pick #(
  parameter int N   = 8,
  parameter int IXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   hit,
  input  logic [N-1:0]   blk,
  output logic           any_hit,
  output logic           any_blk,
  output logic [IXW-1:0] idx
);

  logic [IXW-1:0] bidx, hidx;

  always_comb begin
    bidx = '0;
    hidx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (blk[i]) bidx = IXW'(i);
      if (hit[i]) hidx = IXW'(i);
    end
  end

  assign any_hit = |hit;
  assign any_blk = |blk;
  assign idx     = any_blk ? bidx : hidx;

  // R9: the reported region blocks and no lower-numbered region blocks
  assert_lowest_blocker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_blk |-> (blk[idx] && ((blk & ((N'(1) << idx) - N'(1))) == '0)));

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rgd_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int IDW   = 12,
  parameter int DW    = 32,
  parameter int MINSH = 12,
  parameter int RIW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RIW+2:0] cfg_addr,
  input  logic [DW-1:0]  cfg_data,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic [IDW-1:0] req_id,
  input  logic           req_secure,
  output logic           rsp_valid,
  output logic           rsp_allow,
  output logic           rsp_hit,
  output logic [RIW-1:0] rsp_region
);

  fld_e           fld;
  logic [RIW-1:0] sel;
  assign fld = fld_e'(cfg_addr[2:0]);
  assign sel = cfg_addr[RIW+2:3];

  // global security setting
  glb_t glb_q, glb_d;
  logic glb_we;
  assign glb_we = cfg_we && (fld == FLD_GLB);
  assign glb_d  = glb_t'(cfg_data[GLB_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_q <= '0;
    else if (glb_we) glb_q <= glb_d;
  end

  // regions
  logic [NREG-1:0] r_hit, r_blk;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic we_g;
      assign we_g = cfg_we && (fld != FLD_GLB) && (sel == RIW'(g));
      rgd_region #(.AW(AW), .IDW(IDW), .DW(DW), .MINSH(MINSH)) u_region (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (we_g),
        .wr_fld     (fld),
        .wr_data    (cfg_data),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_id     (req_id),
        .req_secure (req_secure),
        .hit        (r_hit[g]),
        .blk        (r_blk[g])
      );
    end
  endgenerate

  logic           any_hit, any_blk;
  logic [RIW-1:0] pick_idx;

  rgd_pick #(.N(NREG), .IXW(RIW)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (r_hit),
    .blk     (r_blk),
    .any_hit (any_hit),
    .any_blk (any_blk),
    .idx     (pick_idx)
  );

  // verdict
  logic glb_blk, allow_d;
  assign glb_blk = !req_secure && (req_write ? !glb_q.ns_wr : !glb_q.ns_rd);
  assign allow_d = !any_blk && !glb_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_allow  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
    end else if (req_valid) begin
      rsp_allow  <= allow_d;
      rsp_hit    <= any_hit;
      rsp_region <= pick_idx;
    end
  end

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_ns_read_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_secure && !req_write && !glb_q.ns_rd) |=> !rsp_allow);

  assert_nohit_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_region == '0));

  assert_glb_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    glb_we |=> (glb_q == $past(glb_d)));

endmodule

// File: tb/region_guard_tb.sv
module region_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_data;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic [11:0] req_id;
  logic        req_secure;
  logic        rsp_valid, rsp_allow, rsp_hit;
  logic [2:0]  rsp_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  region_guard u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_data,
    .req_valid, .req_addr, .req_write, .req_id, .req_secure,
    .rsp_valid, .rsp_allow, .rsp_hit, .rsp_region
  );

  // {write, secure, id[11:0], addr[31:0], exp_allow, exp_hit, exp_region[2:0]}
  localparam int NV = 14;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'h009, 32'h1000_0100, 1'b1, 1'b1, 3'd0},  // R5 A match
    {1'b0, 1'b1, 12'hF89, 32'h1000_0100, 1'b1, 1'b1, 3'd0},  // R5 masked bits
    {1'b0, 1'b1, 12'h00A, 32'h1000_0100, 1'b0, 1'b1, 3'd0},  // R5 no match
    {1'b0, 1'b1, 12'h047, 32'h1000_0100, 1'b1, 1'b1, 3'd0},  // R5 B match
    {1'b0, 1'b0, 12'h009, 32'h1000_0100, 1'b0, 1'b1, 3'd0},  // R8 ns read denied
    {1'b1, 1'b1, 12'h009, 32'h1000_8010, 1'b0, 1'b1, 3'd1},  // R9 higher region blames
    {1'b1, 1'b1, 12'h1AB, 32'h1000_8010, 1'b0, 1'b1, 3'd0},  // R9 both hit, lowest
    {1'b0, 1'b1, 12'h1AB, 32'h1000_8010, 1'b0, 1'b1, 3'd0},  // R4 read prot region0
    {1'b1, 1'b0, 12'h000, 32'h4001_0000, 1'b1, 1'b1, 3'd2},  // R4 no prot any id
    {1'b0, 1'b0, 12'h7FF, 32'h4010_0000, 1'b1, 1'b0, 3'd0},  // R3 just past window
    {1'b1, 1'b1, 12'h123, 32'h0000_0000, 1'b1, 1'b0, 3'd0},  // R10 no hit
    {1'b0, 1'b1, 12'hABC, 32'h400F_FFFC, 1'b1, 1'b1, 3'd2},  // R3 last word
    {1'b1, 1'b1, 12'h009, 32'h1000_FFFC, 1'b1, 1'b1, 3'd0},  // R3 last word 64KB
    {1'b1, 1'b1, 12'h009, 32'h1001_0000, 1'b1, 1'b0, 3'd0}   // R3 past 64KB
  };

  task automatic cfgw(input int rg, input int fld, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = {3'(rg), 3'(fld)};
    cfg_data  = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic send(input logic wr, input logic sec, input logic [11:0] id,
                      input logic [31:0] a);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_secure = sec;
    req_id     = id;
    req_addr   = a;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_rsp(input string tag, input logic ea, input logic eh,
                            input logic [2:0] er);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_allow !== ea || rsp_hit !== eh || rsp_region !== er) begin
      fails++;
      $display("FAIL %s: valid/allow/hit/region = %b/%b/%b/%0d expected 1/%b/%b/%0d",
               tag, rsp_valid, rsp_allow, rsp_hit, rsp_region, ea, eh, er);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_id = '0; req_secure = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: secure-only after reset, regions off
    send(1'b0, 1'b0, 12'h001, 32'h1000_0000); expect_rsp("R1 ns read", 1'b0, 1'b0, 3'd0);
    send(1'b1, 1'b1, 12'h001, 32'h1000_0000); expect_rsp("R1 s write", 1'b1, 1'b0, 3'd0);

    // R2: idle cycle yields no response
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: rsp_valid=%b expected 0 after idle", rsp_valid);
    end

    // R11 setup: region0 64KB, rd+wr prot, A=009/07F, B=047/FFF, secure only
    cfgw(0, 1, 32'h1000_0000); cfgw(0, 2, 32'h009); cfgw(0, 3, 32'h07F);
    cfgw(0, 4, 32'h047); cfgw(0, 5, 32'hFFF); cfgw(0, 0, 32'h047);
    // region1 4KB, write prot, A=100/F00, B=000/FFF, all security bits
    cfgw(1, 1, 32'h1000_8000); cfgw(1, 2, 32'h100); cfgw(1, 3, 32'hF00);
    cfgw(1, 4, 32'h000); cfgw(1, 5, 32'hFFF); cfgw(1, 6, 32'hF); cfgw(1, 0, 32'h005);
    // region2 1MB, no prot, all security bits
    cfgw(2, 1, 32'h4000_0000); cfgw(2, 6, 32'hF); cfgw(2, 0, 32'h081);
    // global: admit ns read and ns write
    cfgw(5, 7, 32'h3);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][50], VEC[i][49], VEC[i][48:37], VEC[i][36:5]);
      expect_rsp($sformatf("R3/R4/R5/R8/R9/R10 vector %0d", i),
                 VEC[i][4], VEC[i][3], VEC[i][2:0]);
    end

    // R6: invert on region2 with read prot, both comparators on 055
    cfgw(2, 2, 32'h055); cfgw(2, 3, 32'hFFF); cfgw(2, 4, 32'h055); cfgw(2, 5, 32'hFFF);
    cfgw(2, 0, 32'h08B);
    send(1'b0, 1'b1, 12'h055, 32'h4000_0000); expect_rsp("R6 matched id denied", 1'b0, 1'b1, 3'd2);
    send(1'b0, 1'b1, 12'h056, 32'h4000_0000); expect_rsp("R6 other id admitted", 1'b1, 1'b1, 3'd2);
    send(1'b1, 1'b1, 12'h055, 32'h4000_0000); expect_rsp("R6 R4 write unprotected", 1'b1, 1'b1, 3'd2);

    // R3: misaligned base 0x5000_3000 with 16KB -> block 0x5000_0000..0x5000_3FFF, secure only
    cfgw(3, 1, 32'h5000_3000); cfgw(3, 0, 32'h021);
    send(1'b0, 1'b0, 12'h000, 32'h5000_0000); expect_rsp("R3 misaligned base start", 1'b0, 1'b1, 3'd3);
    send(1'b0, 1'b0, 12'h000, 32'h5000_4000); expect_rsp("R3 misaligned base past", 1'b1, 1'b0, 3'd0);

    // R8: non-secure-only region admits secure masters
    cfgw(4, 1, 32'h6000_0000); cfgw(4, 6, 32'hC); cfgw(4, 0, 32'h001);
    send(1'b1, 1'b1, 12'h000, 32'h6000_0000); expect_rsp("R8 secure into ns region", 1'b1, 1'b1, 3'd4);
    send(1'b1, 1'b0, 12'h000, 32'h6000_0000); expect_rsp("R8 ns write ns region", 1'b1, 1'b1, 3'd4);
    cfgw(4, 6, 32'h1);
    send(1'b1, 1'b1, 12'h000, 32'h6000_0000); expect_rsp("R8 secure write no bit", 1'b0, 1'b1, 3'd4);
    send(1'b0, 1'b1, 12'h000, 32'h6000_0000); expect_rsp("R8 secure read bit", 1'b1, 1'b1, 3'd4);

    // R7: global ns write off, ns read on
    cfgw(0, 7, 32'h1);
    send(1'b1, 1'b0, 12'h000, 32'h0000_0000); expect_rsp("R7 ns write blocked", 1'b0, 1'b0, 3'd0);
    send(1'b0, 1'b0, 12'h000, 32'h0000_0000); expect_rsp("R7 ns read admitted", 1'b1, 1'b0, 3'd0);

    // R3: disabled region never hits
    cfgw(3, 0, 32'h020);
    send(1'b0, 1'b0, 12'h000, 32'h5000_0000); expect_rsp("R3 disabled region", 1'b1, 1'b0, 3'd0);

    // R3: size code above 20 acts as whole space
    cfgw(6, 1, 32'h0000_0000); cfgw(6, 6, 32'h3); cfgw(6, 0, 32'h1F1);
    send(1'b0, 1'b0, 12'h000, 32'hF000_0000); expect_rsp("R3 oversize code", 1'b0, 1'b1, 3'd6);

    @(negedge clk); req_valid = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule